// File: doc/BRIEF.md
# Eight-Input Vectored Interrupt Controller

This block collects eight edge-triggered interrupt lines and resolves them by fixed priority, with input 0 the most urgent. It raises one interrupt output and, on a single-cycle acknowledge, returns an 8-bit vector. The vector is built from a programmable base and the number of the winning input. Software reaches the block through two addresses. The command address starts initialization, selects which status register is read back, and retires a specific in-service level. The data address carries the initialization words and, once initialization is done, the mask register.

Initialization is a short word sequence run by a state machine with four states. `PIC_READY` is the normal operating state. A command write with bit 4 set moves it to `PIC_GET_BASE`, which takes the vector base from the next data write. `PIC_GET_BASE` then moves to `PIC_GET_CASC`, which takes the cascade word. If bit 0 of the starting command was set, `PIC_GET_CASC` moves to `PIC_GET_MODE`, which takes the mode word and returns to `PIC_READY`. If that bit was clear, `PIC_GET_CASC` returns to `PIC_READY` directly. A start command seen in any state restarts the sequence at `PIC_GET_BASE`.

The cascade word is stored and presented on an output. In a master it is a bitmask of the inputs that carry a downstream controller. In a slave it is a 3-bit identity. Bit 1 of the mode word selects automatic end of interrupt.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, int_out is low, the command-address readback shows the request register as 0x00, the data-address readback shows the mask as 0xFF, and casc_cfg is 0x00.
- R2: A command write with bit 4 set starts initialization. The following data writes are taken in order as the vector base, then the cascade word (shown on casc_cfg), then the mode word, but only when bit 0 of the start command was 1.
- R3: The vector returned on acknowledge is the base word's bits 7:3 followed by the 3-bit number of the acknowledged input.
- R4: Outside initialization, data-address writes and reads access the mask register, where bit n set masks input n. Data writes during initialization never change the mask. The mask becomes 0x00 when the sequence completes.
- R5: A rising edge on input n sets request bit n. A line held high does not set the bit again after it is cleared. A line that drops before acknowledge clears its request bit.
- R6: Priority is fixed, with input 0 highest. int_out is high only when an unmasked request has a higher priority than every set in-service bit.
- R7: An acknowledge of a valid request clears that request bit and, unless automatic end of interrupt is on, sets the matching in-service bit.
- R8: When bit 1 of the mode word is 1, acknowledge leaves the in-service register unchanged.
- R9: Command write 0x0A selects the request register and 0x0B selects the in-service register for command-address reads.
- R10: Command write 0x60+L, with L from 0 to 7, clears in-service bit L and no other bit.
- R11: An acknowledge with no valid request returns the level-7 vector and leaves the in-service register unchanged. This also happens when input 7 is masked.
- R12: A start command clears the request and in-service registers and points readback at the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register address: 0 command, 1 data |
| reg_wr | input | 1 | Write strobe for the selected address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Readback of the selected address |
| irq_in | input | 8 | Interrupt request lines, rising-edge sensitive |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Single-cycle acknowledge |
| int_vec | output | 8 | Vector, valid while int_ack is high |
| casc_cfg | output | 8 | Stored cascade word |

## Verification
The bench builds the block with its default parameters: eight inputs, 8-bit words and a reset mask of all ones. At these values the readback, mask and vector share one byte. The bench can therefore check every in-service and request bit position directly, and it can compare vector bases such as 0x20, 0x70 and 0x48 against the level numbers. The default reset mask also makes the blocked state before the first initialization observable. Two start-command shapes are exercised: one that includes the mode word and one that omits it. Both reach `PIC_READY` through the transitions listed above.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    localparam int PIC_W     = 8;
    localparam int PIC_IDX_W = 3;

    typedef enum logic [1:0] {
        PIC_READY,
        PIC_GET_BASE,
        PIC_GET_CASC,
        PIC_GET_MODE
    } pic_init_e;

    localparam int START_BIT     = 4;
    localparam int NEED_MODE_BIT = 0;
    localparam int AEOI_BIT      = 1;

    localparam logic [7:0] CMD_SEL_IRR  = 8'h0A;
    localparam logic [7:0] CMD_SEL_ISR  = 8'h0B;
    localparam logic [4:0] CMD_SEOI_TAG = 5'b01100;
endpackage

// File: rtl/pic8_init_seq.sv
module pic8_init_seq
    import pic8_pkg::*;
#(
    parameter int W     = PIC_W,
    parameter int IDX_W = PIC_IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic               data_wr,
    input  logic [W-1:0]       wdata,
    output logic               start_o,
    output logic               done_o,
    output logic               mask_wr_o,
    output logic               ready_o,
    output logic               base_phase_o,
    output logic [W-IDX_W-1:0] base_o,
    output logic [W-1:0]       casc_o,
    output logic               aeoi_o
);
    pic_init_e state_q, state_d;
    logic      need_mode_q;
    logic      start_cmd;

    assign start_cmd = cmd_wr && wdata[START_BIT];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PIC_READY;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (start_cmd) begin
            state_d = PIC_GET_BASE;
        end else if (data_wr) begin
            unique case (state_q)
                PIC_READY:    state_d = PIC_READY;
                PIC_GET_BASE: state_d = PIC_GET_CASC;
                PIC_GET_CASC: state_d = need_mode_q ? PIC_GET_MODE : PIC_READY;
                PIC_GET_MODE: state_d = PIC_READY;
            endcase
        end
    end

    // outputs
    always_comb begin
        start_o      = start_cmd;
        done_o       = 1'b0;
        mask_wr_o    = 1'b0;
        ready_o      = 1'b0;
        base_phase_o = 1'b0;
        unique case (state_q)
            PIC_READY: begin
                ready_o   = 1'b1;
                mask_wr_o = data_wr;
            end
            PIC_GET_BASE: base_phase_o = 1'b1;
            PIC_GET_CASC: done_o = data_wr && !need_mode_q;
            PIC_GET_MODE: done_o = data_wr;
        endcase
    end

    // configuration words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            need_mode_q <= 1'b0;
            base_o      <= '0;
            casc_o      <= '0;
            aeoi_o      <= 1'b0;
        end else if (start_cmd) begin
            need_mode_q <= wdata[NEED_MODE_BIT];
            aeoi_o      <= 1'b0;
        end else if (data_wr) begin
            unique case (state_q)
                PIC_READY:    ;
                PIC_GET_BASE: base_o <= wdata[W-1:IDX_W];
                PIC_GET_CASC: casc_o <= wdata;
                PIC_GET_MODE: aeoi_o <= wdata[AEOI_BIT];
            endcase
        end
    end
endmodule

// File: rtl/pic8_req_latch.sv
module pic8_req_latch
    import pic8_pkg::*;
#(
    parameter int W = PIC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] irq_i,
    input  logic         clr_all_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] irr_o
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic prev_q;
        logic rise;
        assign rise = irq_i[g] && !prev_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q   <= 1'b0;
                irr_o[g] <= 1'b0;
            end else begin
                prev_q <= irq_i[g];
                if (clr_all_i || clr_i[g]) irr_o[g] <= 1'b0;
                else                       irr_o[g] <= (irr_o[g] && irq_i[g]) || rise;
            end
        end
    end
endmodule

// File: rtl/pic8_prio_res.sv
module pic8_prio_res
    import pic8_pkg::*;
#(
    parameter int W     = PIC_W,
    parameter int IDX_W = PIC_IDX_W
) (
    input  logic [W-1:0]     req_i,
    input  logic [W-1:0]     isr_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    logic             req_found, isr_found;
    logic [IDX_W-1:0] isr_idx;

    always_comb begin
        req_found = 1'b0;
        isr_found = 1'b0;
        idx_o     = '0;
        isr_idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                req_found = 1'b1;
                idx_o     = IDX_W'(i);
            end
            if (isr_i[i]) begin
                isr_found = 1'b1;
                isr_idx   = IDX_W'(i);
            end
        end
        hit_o = req_found && (!isr_found || (idx_o < isr_idx));
    end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
#(
    parameter int          W          = PIC_W,
    parameter int          IDX_W      = PIC_IDX_W,
    parameter logic [7:0]  RESET_MASK = 8'hFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_sel,
    input  logic         reg_wr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic [W-1:0] irq_in,
    output logic         int_out,
    input  logic         int_ack,
    output logic [W-1:0] int_vec,
    output logic [W-1:0] casc_cfg
);
    localparam int BASE_W = W - IDX_W;
    localparam logic [IDX_W-1:0] SPUR_LVL = {IDX_W{1'b1}};

    logic              cmd_wr, data_wr;
    logic              start, done, mask_wr, ready, base_phase, aeoi;
    logic [BASE_W-1:0] base;
    logic [W-1:0]      mask_q, isr_q, irr, cand, seoi_clr, take_hot;
    logic              rsel_isr_q, hit, take, seoi_hit;
    logic [IDX_W-1:0]  lvl, vec_lvl;

    assign cmd_wr  = reg_wr && !reg_sel;
    assign data_wr = reg_wr && reg_sel;

    pic8_init_seq #(.W(W), .IDX_W(IDX_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .data_wr      (data_wr),
        .wdata        (reg_wdata),
        .start_o      (start),
        .done_o       (done),
        .mask_wr_o    (mask_wr),
        .ready_o      (ready),
        .base_phase_o (base_phase),
        .base_o       (base),
        .casc_o       (casc_cfg),
        .aeoi_o       (aeoi)
    );

    pic8_req_latch #(.W(W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_i     (irq_in),
        .clr_all_i (start),
        .clr_i     (take_hot),
        .irr_o     (irr)
    );

    assign cand = irr & ~mask_q;

    pic8_prio_res #(.W(W), .IDX_W(IDX_W)) u_prio (
        .req_i (cand),
        .isr_i (isr_q),
        .hit_o (hit),
        .idx_o (lvl)
    );

    assign int_out  = hit && ready;
    assign take     = int_ack && int_out;
    assign vec_lvl  = take ? lvl : SPUR_LVL;
    assign int_vec  = {base, vec_lvl};
    assign take_hot = take ? (W'(1) << lvl) : '0;

    assign seoi_hit = cmd_wr && (reg_wdata[W-1:IDX_W] == CMD_SEOI_TAG);
    assign seoi_clr = seoi_hit ? (W'(1) << reg_wdata[IDX_W-1:0]) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= RESET_MASK;
        else if (done)    mask_q <= '0;
        else if (mask_wr) mask_q <= reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || start)                     rsel_isr_q <= 1'b0;
        else if (cmd_wr && reg_wdata == CMD_SEL_ISR) rsel_isr_q <= 1'b1;
        else if (cmd_wr && reg_wdata == CMD_SEL_IRR) rsel_isr_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || start) isr_q <= '0;
        else                 isr_q <= (isr_q & ~seoi_clr) | (aeoi ? '0 : take_hot);
    end

    assign reg_rdata = reg_sel ? mask_q : (rsel_isr_q ? isr_q : irr);
endmodule

// File: rtl/pic8_chk.sv
module pic8_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       int_ack,
    input logic       int_out,
    input logic [2:0] vec_lvl,
    input logic [7:0] isr,
    input logic [7:0] irr,
    input logic [7:0] mask,
    input logic       aeoi,
    input logic       cmd_wr,
    input logic       data_wr,
    input logic       base_phase
);
    // R11
    spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_out) |-> (vec_lvl == 3'd7));

    // R11
    spur_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_out && !cmd_wr) |=> $stable(isr));

    // R8
    aeoi_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && aeoi && !cmd_wr) |=> $stable(isr));

    // R7
    ack_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out && !aeoi && !cmd_wr) |=> (isr != 8'h00));

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && base_phase) |=> $stable(mask));

    // R6
    int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~mask) != 8'h00));
endmodule

bind pic8_ctrl pic8_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_ack    (int_ack),
    .int_out    (int_out),
    .vec_lvl    (vec_lvl),
    .isr        (isr_q),
    .irr        (irr),
    .mask       (mask_q),
    .aeoi       (aeoi),
    .cmd_wr     (cmd_wr),
    .data_wr    (data_wr),
    .base_phase (base_phase)
);

// File: tb/pic8_ctrl_tb.sv
`timescale 1ns/1ps
module pic8_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       int_out;
    logic       int_ack = 1'b0;
    logic [7:0] int_vec;
    logic [7:0] casc_cfg;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pic8_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_in    (irq_in),
        .int_out   (int_out),
        .int_ack   (int_ack),
        .int_vec   (int_vec),
        .casc_cfg  (casc_cfg)
    );

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic set_irq(input int n, input logic v);
        @(negedge clk);
        irq_in[n] = v;
        @(negedge clk);
    endtask

    task automatic ack(input string req, input logic [7:0] exp);
        @(negedge clk);
        int_ack = 1'b1;
        #1 chk8(req, int_vec, exp);
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic rd_isr(input string req, input logic [7:0] exp);
        logic [7:0] v;
        wr(1'b0, 8'h0B);
        rd(1'b0, v);
        chk8(req, v, exp);
        wr(1'b0, 8'h0A);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        #1 chk8("R1 int_out", {7'b0, int_out}, 8'h00);
        rd(1'b0, v); chk8("R1 irr", v, 8'h00);
        rd(1'b1, v); chk8("R1 mask", v, 8'hFF);
        chk8("R1 casc", casc_cfg, 8'h00);
    endtask

    task automatic t_init_master();
        logic [7:0] v;
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h20);
        rd(1'b1, v); chk8("R4 mask during init", v, 8'hFF);
        wr(1'b1, 8'h04);
        chk8("R2 casc word", casc_cfg, 8'h04);
        rd(1'b1, v); chk8("R2 mode pending", v, 8'hFF);
        wr(1'b1, 8'h01);
        rd(1'b1, v); chk8("R4 mask cleared", v, 8'h00);
    endtask

    task automatic t_edge_ack();
        logic [7:0] v;
        set_irq(3, 1'b1);
        #1 chk8("R5 int after edge", {7'b0, int_out}, 8'h01);
        rd(1'b0, v); chk8("R5 irr bit3", v, 8'h08);
        ack("R3 vector lvl3", 8'h23);
        #1 chk8("R7 int after ack", {7'b0, int_out}, 8'h00);
        rd_isr("R7 isr bit3", 8'h08);
        rd(1'b0, v); chk8("R5 held line no relatch", v, 8'h00);
    endtask

    task automatic t_priority();
        logic [7:0] v;
        set_irq(5, 1'b1);
        #1 chk8("R6 lower blocked", {7'b0, int_out}, 8'h00);
        rd(1'b0, v); chk8("R9 irr readback", v, 8'h20);
        set_irq(1, 1'b1);
        #1 chk8("R6 higher preempts", {7'b0, int_out}, 8'h01);
        ack("R6 vector lvl1", 8'h21);
        rd_isr("R7 nested isr", 8'h0A);
        wr(1'b0, 8'h61);
        rd_isr("R10 clear only bit1", 8'h08);
        #1 chk8("R6 still blocked", {7'b0, int_out}, 8'h00);
        wr(1'b0, 8'h63);
        #1 chk8("R6 unblocked", {7'b0, int_out}, 8'h01);
        ack("R3 vector lvl5", 8'h25);
        rd_isr("R10 isr lvl5", 8'h20);
        wr(1'b0, 8'h65);
        rd_isr("R10 isr empty", 8'h00);
        set_irq(1, 1'b0); set_irq(3, 1'b0); set_irq(5, 1'b0);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        wr(1'b1, 8'h04);
        set_irq(2, 1'b1);
        #1 chk8("R4 masked no int", {7'b0, int_out}, 8'h00);
        rd(1'b1, v); chk8("R4 mask readback", v, 8'h04);
        rd(1'b0, v); chk8("R5 masked still latched", v, 8'h04);
        wr(1'b1, 8'h00);
        #1 chk8("R4 unmask int", {7'b0, int_out}, 8'h01);
        ack("R3 vector lvl2", 8'h22);
        wr(1'b0, 8'h62);
        set_irq(2, 1'b0);
    endtask

    task automatic t_spurious();
        logic [7:0] v;
        set_irq(6, 1'b1);
        #1 chk8("R5 int lvl6", {7'b0, int_out}, 8'h01);
        set_irq(6, 1'b0);
        #1 chk8("R5 dropped line", {7'b0, int_out}, 8'h00);
        rd(1'b0, v); chk8("R5 irr dropped", v, 8'h00);
        ack("R11 spurious vector", 8'h27);
        rd_isr("R11 isr untouched", 8'h00);
        wr(1'b1, 8'h80);
        ack("R11 spurious with lvl7 masked", 8'h27);
        rd_isr("R11 isr untouched masked", 8'h00);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_reinit_slave();
        logic [7:0] v;
        set_irq(4, 1'b1);
        ack("R3 vector lvl4", 8'h24);
        set_irq(4, 1'b0);
        set_irq(6, 1'b1);
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'h10);
        rd(1'b0, v); chk8("R12 readback irr cleared", v, 8'h00);
        #1 chk8("R12 no int in init", {7'b0, int_out}, 8'h00);
        wr(1'b1, 8'h70);
        wr(1'b1, 8'h02);
        chk8("R2 slave id", casc_cfg, 8'h02);
        rd(1'b1, v); chk8("R2 done without mode", v, 8'h00);
        rd_isr("R12 isr cleared", 8'h00);
        wr(1'b1, 8'h33);
        rd(1'b1, v); chk8("R4 mask write", v, 8'h33);
        wr(1'b1, 8'h00);
        set_irq(6, 1'b0);
        set_irq(4, 1'b1);
        ack("R3 new base", 8'h74);
        rd_isr("R7 isr after reinit", 8'h10);
        wr(1'b0, 8'h64);
        set_irq(4, 1'b0);
    endtask

    task automatic t_aeoi();
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h48);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h03);
        set_irq(0, 1'b1);
        #1 chk8("R6 lvl0 int", {7'b0, int_out}, 8'h01);
        ack("R3 vector lvl0", 8'h48);
        rd_isr("R8 auto eoi isr", 8'h00);
        #1 chk8("R8 int cleared", {7'b0, int_out}, 8'h00);
        set_irq(0, 1'b0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init_master();
        t_edge_ack();
        t_priority();
        t_mask();
        t_spurious();
        t_reinit_slave();
        t_aeoi();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule